// File: doc/BRIEF.md
# Register-Mapped Multiply, Divide and Shift Coprocessor

The unit is a small arithmetic coprocessor behind a byte-wide register port. A host loads operands into six data bytes, writes an operation code and a 5-bit shift amount into a mode byte, then writes a start bit into a control byte. The operation runs in one or more clock cycles. The host polls the start bit, which reads as a busy flag, until it falls. Results are then read back from the same data bytes, because every operation writes its result in place. The whole 32-bit operand in bytes 3..0 is called LO, and the 16-bit operand in bytes 5..4 is called HI.

The unit offers unsigned 16x16 multiply, 16/16 and 32/16 divide with remainder, 32-bit logical shifts by a programmed amount, and normalization. Normalization shifts the word left until its top bit is set and reports the distance in the shift-amount field. An overflow flag reports a zero divisor, or a product that does not fit in 16 bits. A soft-reset bit aborts any operation and clears the mode byte.

The controller is a state machine with five states:
- ST_IDLE accepts register writes.
- ST_ONE completes shifts, normalization, undefined codes and zero-divisor divides in one cycle.
- ST_MUL runs 16 shift-add steps.
- ST_DIV runs 16 or 32 restoring shift-subtract steps.
- ST_RST lasts one cycle after a soft reset.

The transitions are:
- ST_IDLE goes to ST_MUL, ST_DIV or ST_ONE on a start, chosen by the operation code and the divisor.
- ST_MUL and ST_DIV return to ST_IDLE after their final step.
- ST_ONE always returns to ST_IDLE.
- Any state except ST_RST goes to ST_RST on a soft-reset write.
- ST_RST always returns to ST_IDLE.

Top module: `mdu_unit`

## Requirements
- R1: After the asynchronous reset, every readable byte reads 0x00 and `busy` is low.
- R2: The address map is as follows.
  - Addresses 0..5 hold data bytes, where byte k of LO is address k and the bytes of HI are addresses 4 and 5.
  - Address 6 is the mode byte: bits 7:5 hold the operation code and bits 4:0 hold the shift amount.
  - Address 7 is the control byte: bit 0 is start/busy, bit 1 is soft reset and bit 2 is overflow.
  - In idle, the data and mode bytes read back what was written. Addresses above 7 read zero.
- R3: Code 100 multiplies LO[15:0] by HI and writes the 32-bit product to LO. Busy stays high for 16 cycles. Overflow is set exactly when the product exceeds 0xFFFF.
- R4: Code 101 divides LO[15:0] by a nonzero HI. The quotient goes to LO[15:0] and the remainder to HI, and LO[31:16] is kept. Busy stays high for 16 cycles.
- R5: Code 110 divides LO by a nonzero HI. The quotient goes to LO and the remainder to HI. Busy stays high for 32 cycles.
- R6: A divide with HI equal to zero sets overflow and leaves all six data bytes unchanged. Busy stays high for one cycle.
- R7: Code 000 shifts LO right and code 001 shifts it left, by the shift amount, filling with zeros. Busy stays high for one cycle.
- R8: Code 010 shifts a nonzero LO left until bit 31 is 1 and writes the distance into the shift amount. A zero LO stays zero and the shift amount becomes 31. Busy stays high for one cycle.
- R9: In idle, any write to the mode byte or the control byte clears overflow.
- R10: While busy, writes to the data bytes, to the mode byte, and to the control byte without bit 1 set have no effect.
- R11: Writing a 1 to control bit 1 aborts any operation.
  - It clears the mode byte, the overflow flag and busy, and keeps the data bytes.
  - The soft-reset bit reads 1 for exactly one cycle and then 0.
  - All writes during that cycle are ignored.
- R12: The undefined codes 011 and 111 finish in one cycle, change no data byte, and leave overflow at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| busy | output | 1 | High while an operation runs |

## Verification
The assertions check, on every cycle:
- the one-cycle width of the soft-reset pulse and the state it leaves behind;
- that the data bytes stay frozen during the iterative steps and after a zero-divisor divide;
- that the overflow flag agrees with the upper half of a finished product;
- that normalization leaves the top bit set;
- that a divide step keeps the remainder below the divisor.

The numeric results and the exact busy lengths can only be shown by the bench's scenarios:
- products on both sides of the 16-bit limit;
- both divide widths, including an all-ones dividend;
- shifts by zero and by 31;
- normalization of zero and of an already-normalized word;
- writes and soft resets that land in the middle of an operation.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 5;
    localparam int STEP_W = $clog2(WORD_W) + 1;
    localparam int NDATA  = 6;

    localparam int A_MODE = 6;
    localparam int A_CTRL = 7;

    localparam int CB_GO   = 0;
    localparam int CB_SRST = 1;
    localparam int CB_OVF  = 2;

    localparam logic [2:0] MD_SHR   = 3'b000;
    localparam logic [2:0] MD_SHL   = 3'b001;
    localparam logic [2:0] MD_NORM  = 3'b010;
    localparam logic [2:0] MD_MUL   = 3'b100;
    localparam logic [2:0] MD_DIV16 = 3'b101;
    localparam logic [2:0] MD_DIV32 = 3'b110;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ONE  = 3'd1,
        ST_MUL  = 3'd2,
        ST_DIV  = 3'd3,
        ST_RST  = 3'd4
    } state_e;
endpackage

// File: rtl/mdu_shifter.sv
module mdu_shifter
    import mdu_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    input  logic [CNT_W-1:0]  amt,
    output logic [WORD_W-1:0] shl,
    output logic [WORD_W-1:0] shr,
    output logic [WORD_W-1:0] nrm,
    output logic [CNT_W-1:0]  lz
);
    // Leading-zero count: the highest set bit wins; an all-zero word gives WORD_W-1.
    always_comb begin
        lz = CNT_W'(WORD_W - 1);
        for (int i = 0; i < WORD_W; i++) begin
            if (din[i]) lz = CNT_W'(WORD_W - 1 - i);
        end
    end

    assign shl = din << amt;
    assign shr = din >> amt;
    assign nrm = din << lz;

    // R8: a nonzero word always comes out of normalization with its top bit set.
    always_comb begin
        if (din != '0) p_norm_top_r8: assert (nrm[WORD_W-1]);
    end
endmodule

// File: rtl/mdu_iter.sv
module mdu_iter
    import mdu_pkg::*;
(
    input  logic              is_mul,
    input  logic [WORD_W-1:0] acc,
    input  logic [HALF_W-1:0] rem,
    input  logic [HALF_W-1:0] opnd,
    output logic [WORD_W-1:0] acc_nx,
    output logic [HALF_W-1:0] rem_nx
);
    logic [HALF_W:0]   add_s;
    logic [HALF_W:0]   hsel;
    logic [HALF_W:0]   trial;
    logic [HALF_W-1:0] diff;
    logic              fits;

    always_comb begin
        // One shift-add step of the multiplier.
        add_s = {1'b0, acc[WORD_W-1:HALF_W]} + {1'b0, opnd};
        hsel  = acc[0] ? add_s : {1'b0, acc[WORD_W-1:HALF_W]};

        // One restoring shift-subtract step of the divider.
        trial = {rem, acc[WORD_W-1]};
        fits  = trial >= {1'b0, opnd};
        diff  = trial[HALF_W-1:0] - opnd;

        if (is_mul) begin
            acc_nx = {hsel, acc[HALF_W-1:1]};
            rem_nx = rem;
        end else begin
            acc_nx = {acc[WORD_W-2:0], fits};
            rem_nx = fits ? diff : trial[HALF_W-1:0];
        end
    end

    // R4: a partial remainder below the divisor stays below it after a step.
    always_comb begin
        if (!is_mul && opnd != '0 && rem < opnd) p_rem_bound_r4: assert (rem_nx < opnd);
    end
endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              busy
);
    localparam int LO_BYTES = WORD_W / BYTE_W;
    localparam int HI_BYTES = HALF_W / BYTE_W;

    state_e             st_q, st_d;
    logic [WORD_W-1:0]  lo_q;
    logic [HALF_W-1:0]  hi_q;
    logic [2:0]         mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_q, srst_q;
    logic [WORD_W-1:0]  acc_q, acc_nx;
    logic [HALF_W-1:0]  rem_q, rem_nx, opnd_q;
    logic [STEP_W-1:0]  left_q;

    logic [WORD_W-1:0]  sh_l, sh_r, sh_n;
    logic [CNT_W-1:0]   sh_lz;

    logic wr_data, wr_mode, wr_ctrl, srst_req, go_req, div0, last_step;

    assign wr_data   = bus_we && (bus_addr < ADDR_W'(NDATA));
    assign wr_mode   = bus_we && (bus_addr == ADDR_W'(A_MODE));
    assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(A_CTRL));
    assign srst_req  = wr_ctrl && bus_wdata[CB_SRST] && (st_q != ST_RST);
    assign go_req    = wr_ctrl && bus_wdata[CB_GO] && !bus_wdata[CB_SRST] && (st_q == ST_IDLE);
    assign div0      = (hi_q == '0);
    assign last_step = (left_q == STEP_W'(1));
    assign busy      = (st_q == ST_ONE) || (st_q == ST_MUL) || (st_q == ST_DIV);

    mdu_shifter u_shift (
        .din (lo_q),
        .amt (cnt_q),
        .shl (sh_l),
        .shr (sh_r),
        .nrm (sh_n),
        .lz  (sh_lz)
    );

    mdu_iter u_iter (
        .is_mul (st_q == ST_MUL),
        .acc    (acc_q),
        .rem    (rem_q),
        .opnd   (opnd_q),
        .acc_nx (acc_nx),
        .rem_nx (rem_nx)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (go_req) begin
                    if (mode_q == MD_MUL)                             st_d = ST_MUL;
                    else if (mode_q == MD_DIV16 || mode_q == MD_DIV32) st_d = div0 ? ST_ONE : ST_DIV;
                    else                                              st_d = ST_ONE;
                end
            end
            ST_ONE:         st_d = ST_IDLE;
            ST_MUL, ST_DIV: if (last_step) st_d = ST_IDLE;
            ST_RST:         st_d = ST_IDLE;
            default:        st_d = ST_IDLE;
        endcase
        if (srst_req) st_d = ST_RST;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Registers and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            mode_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            srst_q <= 1'b0;
            acc_q  <= '0;
            rem_q  <= '0;
            opnd_q <= '0;
            left_q <= '0;
        end else if (srst_req) begin
            srst_q <= 1'b1;
            mode_q <= '0;
            cnt_q  <= '0;
            ovf_q  <= 1'b0;
            left_q <= '0;
        end else begin
            srst_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (wr_data) begin
                        for (int i = 0; i < LO_BYTES; i++)
                            if (bus_addr == ADDR_W'(i)) lo_q[i*BYTE_W +: BYTE_W] <= bus_wdata;
                        for (int i = 0; i < HI_BYTES; i++)
                            if (bus_addr == ADDR_W'(LO_BYTES + i)) hi_q[i*BYTE_W +: BYTE_W] <= bus_wdata;
                    end
                    if (wr_mode) begin
                        mode_q <= bus_wdata[BYTE_W-1 -: 3];
                        cnt_q  <= bus_wdata[CNT_W-1:0];
                        ovf_q  <= 1'b0;
                    end
                    if (wr_ctrl) ovf_q <= 1'b0;
                    if (go_req) begin
                        opnd_q <= hi_q;
                        rem_q  <= '0;
                        if (mode_q == MD_MUL)        acc_q <= {{HALF_W{1'b0}}, lo_q[HALF_W-1:0]};
                        else if (mode_q == MD_DIV16) acc_q <= {lo_q[HALF_W-1:0], {HALF_W{1'b0}}};
                        else                         acc_q <= lo_q;
                        left_q <= (mode_q == MD_DIV32) ? STEP_W'(WORD_W) : STEP_W'(HALF_W);
                    end
                end
                ST_ONE: begin
                    case (mode_q)
                        MD_SHR:  lo_q <= sh_r;
                        MD_SHL:  lo_q <= sh_l;
                        MD_NORM: begin
                            lo_q  <= sh_n;
                            cnt_q <= sh_lz;
                        end
                        MD_DIV16, MD_DIV32: ovf_q <= 1'b1;
                        default: ;
                    endcase
                end
                ST_MUL: begin
                    acc_q  <= acc_nx;
                    left_q <= left_q - STEP_W'(1);
                    if (last_step) begin
                        lo_q  <= acc_nx;
                        ovf_q <= |acc_nx[WORD_W-1:HALF_W];
                    end
                end
                ST_DIV: begin
                    acc_q  <= acc_nx;
                    rem_q  <= rem_nx;
                    left_q <= left_q - STEP_W'(1);
                    if (last_step) begin
                        if (mode_q == MD_DIV16) lo_q[HALF_W-1:0] <= acc_nx[HALF_W-1:0];
                        else                    lo_q <= acc_nx;
                        hi_q <= rem_nx;
                    end
                end
                ST_RST: ;
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < LO_BYTES; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = lo_q[i*BYTE_W +: BYTE_W];
        for (int i = 0; i < HI_BYTES; i++)
            if (bus_addr == ADDR_W'(LO_BYTES + i)) bus_rdata = hi_q[i*BYTE_W +: BYTE_W];
        if (bus_addr == ADDR_W'(A_MODE)) bus_rdata = {mode_q, cnt_q};
        if (bus_addr == ADDR_W'(A_CTRL)) begin
            bus_rdata[CB_GO]   = busy;
            bus_rdata[CB_SRST] = srst_q;
            bus_rdata[CB_OVF]  = ovf_q;
        end
    end

    // Assertions
    p_rst_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> !srst_q);
    p_rst_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |-> (mode_q == '0 && cnt_q == '0 && !ovf_q && !busy));
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_MUL || st_q == ST_DIV) && !last_step) |=> ($stable(lo_q) && $stable(hi_q)));
    p_div0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONE && (mode_q == MD_DIV16 || mode_q == MD_DIV32) && !srst_req)
        |=> (ovf_q && $stable(lo_q) && $stable(hi_q)));
    p_mul_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MUL && last_step && !srst_req) |=> (ovf_q == (lo_q[WORD_W-1:HALF_W] != '0)));
    p_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ONE && mode_q == MD_NORM && lo_q != '0 && !srst_req) |=> lo_q[WORD_W-1]);
    p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && (wr_ctrl || wr_mode)) |=> !ovf_q);
endmodule

// File: tb/test_mdu_unit.sv
module test_mdu_unit;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       busy;

    always #(CLK_P/2) clk = ~clk;

    mdu_unit #(.ADDR_W(3)) i_mdu_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .busy      (busy)
    );

    // Behavioural reference model
    logic [31:0] m_lo = '0;
    logic [15:0] m_hi = '0;
    logic [2:0]  m_mode = '0;
    logic [4:0]  m_cnt = '0;
    logic        m_ovf = 1'b0, m_srst = 1'b0, m_busy = 1'b0;
    int          m_left = 0;
    logic [31:0] p_lo = '0;
    logic [15:0] p_hi = '0;
    logic [4:0]  p_cnt = '0;
    logic        p_ovf = 1'b0;

    int    vecs = 0;
    int    errs = 0;
    string req = "R1";
    bit    done = 0;

    task automatic launch();
        logic [31:0] v, prod;
        int n;
        p_lo = m_lo; p_hi = m_hi; p_cnt = m_cnt; p_ovf = 1'b0;
        m_left = 1; m_busy = 1'b1;
        case (m_mode)
            3'b000: p_lo = m_lo >> m_cnt;
            3'b001: p_lo = m_lo << m_cnt;
            3'b010: begin
                v = m_lo; n = 0;
                while (!v[31] && n < 31) begin v = v << 1; n++; end
                p_lo = v; p_cnt = 5'(n);
            end
            3'b100: begin
                prod = 32'(m_lo[15:0]) * 32'(m_hi);
                p_lo = prod; p_ovf = (prod > 32'h0000_FFFF); m_left = 16;
            end
            3'b101: begin
                if (m_hi == 0) p_ovf = 1'b1;
                else begin
                    p_lo[15:0] = m_lo[15:0] / m_hi;
                    p_hi = m_lo[15:0] % m_hi;
                    m_left = 16;
                end
            end
            3'b110: begin
                if (m_hi == 0) p_ovf = 1'b1;
                else begin
                    p_lo = m_lo / 32'(m_hi);
                    p_hi = 16'(m_lo % 32'(m_hi));
                    m_left = 32;
                end
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = '0; m_hi = '0; m_mode = '0; m_cnt = '0;
            m_ovf = 0; m_srst = 0; m_busy = 0; m_left = 0;
        end else if (m_srst) begin
            m_srst = 1'b0;
        end else if (we && addr == 3'd7 && wdata[1]) begin
            m_srst = 1'b1; m_busy = 1'b0; m_left = 0;
            m_mode = '0; m_cnt = '0; m_ovf = 1'b0;
        end else if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 1'b0;
                m_lo = p_lo; m_hi = p_hi; m_cnt = p_cnt; m_ovf = p_ovf;
            end
        end else if (we) begin
            if (addr < 3'd4) m_lo[addr*8 +: 8] = wdata;
            else if (addr < 3'd6) m_hi[(addr-4)*8 +: 8] = wdata;
            else if (addr == 3'd6) begin {m_mode, m_cnt} = wdata; m_ovf = 1'b0; end
            else begin
                m_ovf = 1'b0;
                if (wdata[0]) launch();
            end
        end
    end

    // Compare every cycle, a quarter period after the driving edge
    always @(negedge clk) begin
        logic [7:0] exp;
        #(CLK_P/4);
        if (addr < 3'd4)       exp = m_lo[addr*8 +: 8];
        else if (addr < 3'd6)  exp = m_hi[(addr-4)*8 +: 8];
        else if (addr == 3'd6) exp = {m_mode, m_cnt};
        else                   exp = {5'b0, m_ovf, m_srst, m_busy};
        vecs++;
        if (rdata !== exp || busy !== m_busy) begin
            errs++;
            $display("FAIL %s: addr=%0d rdata=%h busy=%b expected rdata=%h busy=%b",
                     req, addr, rdata, busy, exp, m_busy);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [2:0] a);
        @(negedge clk); we = 1'b0; addr = a;
    endtask

    task automatic sweep(input int n);
        for (int i = 0; i < n; i++) rd(3'(i));
    endtask

    task automatic load(input logic [31:0] lo, input logic [15:0] hi,
                        input logic [2:0] md, input logic [4:0] sc);
        for (int i = 0; i < 4; i++) wr(3'(i), lo[i*8 +: 8]);
        wr(3'd4, hi[7:0]);
        wr(3'd5, hi[15:8]);
        wr(3'd6, {md, sc});
    endtask

    task automatic run_op();
        wr(3'd7, 8'h01);
        sweep(40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        req = "R1";
        repeat (3) rd(3'd0);
        @(negedge clk); rst_n = 1'b1;
        sweep(8);

        req = "R2";
        load(32'hA1B2C3D4, 16'hE5F6, 3'b011, 5'd9);
        sweep(8);

        req = "R3";
        load(32'hDEAD0012, 16'h0034, 3'b100, 5'd0); run_op();
        load(32'h0000FFFF, 16'hFFFF, 3'b100, 5'd0); run_op();
        load(32'h00000100, 16'h00FF, 3'b100, 5'd0); run_op();
        load(32'h00000100, 16'h0100, 3'b100, 5'd0); run_op();

        req = "R4";
        load(32'hCAFE03E8, 16'h0007, 3'b101, 5'd0); run_op();
        load(32'h1234FFFF, 16'h0001, 3'b101, 5'd0); run_op();

        req = "R5";
        load(32'h12345678, 16'h1234, 3'b110, 5'd0); run_op();
        load(32'hFFFFFFFF, 16'h0001, 3'b110, 5'd0); run_op();
        load(32'h0000_0005, 16'hFFFF, 3'b110, 5'd0); run_op();

        req = "R6";
        load(32'h87654321, 16'h0000, 3'b101, 5'd0); run_op();
        load(32'h87654321, 16'h0000, 3'b110, 5'd0); run_op();

        req = "R7";
        load(32'h80000001, 16'h0000, 3'b000, 5'd5);  run_op();
        load(32'h80000003, 16'h0000, 3'b001, 5'd31); run_op();
        load(32'h5A5A5A5A, 16'h0000, 3'b001, 5'd0);  run_op();

        req = "R8";
        load(32'h00012345, 16'h0000, 3'b010, 5'd3); run_op();
        load(32'h00000000, 16'h0000, 3'b010, 5'd3); run_op();
        load(32'h80000000, 16'h0000, 3'b010, 5'd7); run_op();

        req = "R9";
        load(32'h0000FFFF, 16'h0002, 3'b100, 5'd0); run_op();
        wr(3'd6, 8'h80); rd(3'd7); rd(3'd7);
        load(32'h0000FFFF, 16'h0002, 3'b100, 5'd0); run_op();
        wr(3'd7, 8'h00); rd(3'd7); rd(3'd7);

        req = "R10";
        load(32'h00001111, 16'h0003, 3'b100, 5'd0);
        wr(3'd7, 8'h01);
        wr(3'd0, 8'hEE); wr(3'd4, 8'hEE); wr(3'd6, 8'h3F); wr(3'd7, 8'h01);
        sweep(40);

        req = "R11";
        load(32'hFEDCBA98, 16'h0123, 3'b110, 5'd11);
        wr(3'd7, 8'h01);
        sweep(5);
        wr(3'd7, 8'h03);
        wr(3'd0, 8'h55);
        rd(3'd7); rd(3'd7);
        sweep(8);

        req = "R12";
        load(32'h13579BDF, 16'h2468, 3'b011, 5'd4); run_op();
        load(32'h13579BDF, 16'h2468, 3'b111, 5'd4); run_op();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule